// File: doc/BRIEF.md
# Link-Down TLP Disposition Unit

This unit watches the data-link state of every port of a multi-port switch and reacts when one of them drops out of the link-up state. At that moment it sends single-cycle flush commands to the port's ingress frame buffer and to its replay buffer, so that every TLP queued there is discarded without any error being reported. If the failing port is the upstream port, it also asks for a hot reset of the whole switch.

While a downstream link stays down, the unit also sits beside the routing path of the other ports and classifies each TLP that arrives. A TLP whose target bus number falls inside the secondary-to-subordinate range of a downstream port whose link is down gets one of two verdicts. A request is marked Unsupported Request, so that a completion generator elsewhere can answer it. Anything else, such as a completion, is marked for silent drop. The buffers, the completion generator and the routing tables are outside this block. It only produces the control pulses and the per-TLP verdict.

Top module: `linkdown_disposition`

## Requirements
- R1: When a port's `dl_up` bit is sampled low at a clock edge after being sampled high at the edge before, that port's `ifb_flush` bit is high for exactly the one cycle that follows that edge.
- R2: Under the same condition, that port's `rpl_flush` bit is high for exactly the one cycle that follows that edge.
- R3: A drop of the upstream port (index `UP_PORT`) raises `hot_reset_req` for one cycle, in the same cycle as its flush pulses. A drop of a downstream port never raises it.
- R4: A downstream port counts as down from the cycle after its drop is sampled until the first edge at which its `dl_up` is sampled high again. After reset, no port counts as down. The upstream port never counts as down for classification.
- R5: A TLP sampled with `tlp_valid` high gives `cls_valid` high in the following cycle. At most one of `cls_ur` and `cls_drop` is set then, and both are low whenever `cls_valid` is low.
- R6: A TLP that is a request gives `cls_ur`, if three conditions hold: it targets a bus inside the range of a downstream port that counts as down, that port is not the one the TLP arrived on, and the TLP is a request. A TLP is a request when its 5-bit type field `tlp_type[4:1]` is not 4'b0101, which covers memory, I/O, configuration and message types.
- R7: A completion TLP (`tlp_type[4:1]` equal to 4'b0101) under the same targeting conditions gives `cls_drop`.
- R8: The range test is inclusive at both ends: bus numbers equal to the port's secondary bus or to its subordinate bus match, and bus numbers one below secondary or one above subordinate do not.
- R9: A TLP that targets no down downstream port gives `cls_valid` with both `cls_ur` and `cls_drop` low. This covers buses outside every down range, links that have returned to up, and the upstream port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dl_up | input | NUM_PORTS | Data-link-up state of each port |
| sec_bus | input | NUM_PORTS*BUS_W | Secondary bus number of each port, port 0 in the low bits |
| sub_bus | input | NUM_PORTS*BUS_W | Subordinate bus number of each port, port 0 in the low bits |
| tlp_valid | input | 1 | A TLP header is presented for classification |
| tlp_src_port | input | PORT_W | Port on which the TLP arrived |
| tlp_type | input | 5 | Type field of the TLP header |
| tlp_bus | input | BUS_W | Target bus number of the TLP |
| ifb_flush | output | NUM_PORTS | One-cycle flush command to each ingress frame buffer |
| rpl_flush | output | NUM_PORTS | One-cycle flush command to each replay buffer |
| hot_reset_req | output | 1 | One-cycle hot reset request on upstream link loss |
| cls_valid | output | 1 | A classification verdict is present |
| cls_ur | output | 1 | Verdict: treat the TLP as Unsupported Request |
| cls_drop | output | 1 | Verdict: discard the TLP silently |

## Verification
On every cycle the assertions check that flush and hot-reset pulses last one cycle and follow a sampled high-to-low edge of the link state. They also check that a port counted as down had its link low at the edge before, that verdicts never appear without a TLP, and that the kind of verdict agrees with the request or completion type that was sampled. Only the bench scenarios can show the rest. These are the inclusive range boundaries, the exclusion of the arrival port and of the upstream port, the end of filtering once the link returns, and the fact that two down links are each matched on their own ranges.

// File: rtl/ldd_pkg.sv
package ldd_pkg;

    localparam logic [3:0] CPL_TYPE_HI = 4'b0101;

    typedef struct packed {
        logic up;
        logic down;
        logic flush;
        logic hrst;
    } mon_state_t;

    typedef struct packed {
        logic valid;
        logic ur;
        logic drop;
    } verdict_t;

    function automatic logic is_request(input logic [4:0] tlp_type);
        return tlp_type[4:1] != CPL_TYPE_HI;
    endfunction

endpackage

// File: rtl/ldd_port_monitor.sv
module ldd_port_monitor #(
    parameter bit IS_UPSTREAM = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dl_up,
    output logic ifb_flush,
    output logic rpl_flush,
    output logic hot_reset,
    output logic down_active
);
    import ldd_pkg::*;

    mon_state_t st_d, st_q;

    always_comb begin
        logic fell;
        fell         = st_q.up && !dl_up;
        st_d.up      = dl_up;
        st_d.flush   = fell;
        st_d.hrst    = fell && IS_UPSTREAM;
        st_d.down    = !IS_UPSTREAM && (fell || st_q.down) && !dl_up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ifb_flush   = st_q.flush;
    assign rpl_flush   = st_q.flush;
    assign hot_reset   = st_q.hrst;
    assign down_active = st_q.down;

    assert_ifb_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ifb_flush |-> !$past(dl_up) && $past(dl_up, 2));
    assert_ifb_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ifb_flush |=> !ifb_flush);
    assert_rpl_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_flush |=> !rpl_flush);
    assert_down_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        down_active |-> !$past(dl_up));

endmodule

// File: rtl/ldd_tlp_filter.sv
module ldd_tlp_filter #(
    parameter int NUM_PORTS = 4,
    parameter int BUS_W     = 8,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       down_vec,
    input  logic [NUM_PORTS*BUS_W-1:0] sec_bus,
    input  logic [NUM_PORTS*BUS_W-1:0] sub_bus,
    input  logic                       tlp_valid,
    input  logic [PORT_W-1:0]          tlp_src_port,
    input  logic [4:0]                 tlp_type,
    input  logic [BUS_W-1:0]           tlp_bus,
    output logic                       cls_valid,
    output logic                       cls_ur,
    output logic                       cls_drop
);
    import ldd_pkg::*;

    verdict_t vd_d, vd_q;
    logic [NUM_PORTS-1:0] hit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_match
        logic [BUS_W-1:0] lo, hi;
        assign lo     = sec_bus[p*BUS_W +: BUS_W];
        assign hi     = sub_bus[p*BUS_W +: BUS_W];
        assign hit[p] = down_vec[p] && (tlp_src_port != PORT_W'(p))
                        && (tlp_bus >= lo) && (tlp_bus <= hi);
    end

    always_comb begin
        vd_d.valid = tlp_valid;
        vd_d.ur    = tlp_valid && (|hit) && is_request(tlp_type);
        vd_d.drop  = tlp_valid && (|hit) && !is_request(tlp_type);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vd_q <= '0;
        else        vd_q <= vd_d;
    end

    assign cls_valid = vd_q.valid;
    assign cls_ur    = vd_q.ur;
    assign cls_drop  = vd_q.drop;

    assert_verdict_needs_tlp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_ur || cls_drop) |-> cls_valid && $past(tlp_valid));
    assert_verdict_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cls_ur, cls_drop}));
    assert_ur_is_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cls_ur |-> is_request($past(tlp_type)) && $past(|down_vec));
    assert_drop_is_cpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cls_drop |-> !is_request($past(tlp_type)) && $past(|down_vec));

endmodule

// File: rtl/linkdown_disposition.sv
module linkdown_disposition #(
    parameter int NUM_PORTS = 4,
    parameter int UP_PORT   = 0,
    parameter int BUS_W     = 8,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       dl_up,
    input  logic [NUM_PORTS*BUS_W-1:0] sec_bus,
    input  logic [NUM_PORTS*BUS_W-1:0] sub_bus,
    input  logic                       tlp_valid,
    input  logic [PORT_W-1:0]          tlp_src_port,
    input  logic [4:0]                 tlp_type,
    input  logic [BUS_W-1:0]           tlp_bus,
    output logic [NUM_PORTS-1:0]       ifb_flush,
    output logic [NUM_PORTS-1:0]       rpl_flush,
    output logic                       hot_reset_req,
    output logic                       cls_valid,
    output logic                       cls_ur,
    output logic                       cls_drop
);

    logic [NUM_PORTS-1:0] down_vec;
    logic [NUM_PORTS-1:0] hrst_vec;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ldd_port_monitor #(.IS_UPSTREAM(p == UP_PORT)) u_mon (
            .clk        (clk),
            .rst_n      (rst_n),
            .dl_up      (dl_up[p]),
            .ifb_flush  (ifb_flush[p]),
            .rpl_flush  (rpl_flush[p]),
            .hot_reset  (hrst_vec[p]),
            .down_active(down_vec[p])
        );
    end

    assign hot_reset_req = |hrst_vec;

    ldd_tlp_filter #(
        .NUM_PORTS(NUM_PORTS),
        .BUS_W    (BUS_W),
        .PORT_W   (PORT_W)
    ) u_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .down_vec    (down_vec),
        .sec_bus     (sec_bus),
        .sub_bus     (sub_bus),
        .tlp_valid   (tlp_valid),
        .tlp_src_port(tlp_src_port),
        .tlp_type    (tlp_type),
        .tlp_bus     (tlp_bus),
        .cls_valid   (cls_valid),
        .cls_ur      (cls_ur),
        .cls_drop    (cls_drop)
    );

    assert_hot_reset_upstream_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hot_reset_req |-> !$past(dl_up[UP_PORT]) && $past(dl_up[UP_PORT], 2));
    assert_hot_reset_with_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hot_reset_req |-> ifb_flush[UP_PORT] && rpl_flush[UP_PORT]);
    assert_upstream_never_filtered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !down_vec[UP_PORT]);

endmodule

// File: tb/linkdown_disposition_bench.sv
module linkdown_disposition_bench;
    localparam int N  = 4;
    localparam int BW = 8;
    localparam int PW = 2;

    localparam logic [4:0] T_MRD = 5'b00000;
    localparam logic [4:0] T_CFG = 5'b00100;
    localparam logic [4:0] T_MSG = 5'b10000;
    localparam logic [4:0] T_CPL = 5'b01010;
    localparam logic [4:0] T_CPLLK = 5'b01011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] dl_up = '0;
    logic [N*BW-1:0] sec_bus, sub_bus;
    logic tlp_valid = 1'b0;
    logic [PW-1:0] tlp_src_port = '0;
    logic [4:0] tlp_type = '0;
    logic [BW-1:0] tlp_bus = '0;
    logic [N-1:0] ifb_flush, rpl_flush;
    logic hot_reset_req, cls_valid, cls_ur, cls_drop;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Port 0 upstream [1..30]; port 1 [2..4]; port 2 [5..9]; port 3 [10..20]
    assign sec_bus = {8'd10, 8'd5, 8'd2, 8'd1};
    assign sub_bus = {8'd20, 8'd9, 8'd4, 8'd30};

    always #2.5 clk = ~clk;

    linkdown_disposition #(.NUM_PORTS(N), .UP_PORT(0), .BUS_W(BW)) u_linkdown_disposition (
        .clk(clk), .rst_n(rst_n), .dl_up(dl_up), .sec_bus(sec_bus), .sub_bus(sub_bus),
        .tlp_valid(tlp_valid), .tlp_src_port(tlp_src_port), .tlp_type(tlp_type),
        .tlp_bus(tlp_bus), .ifb_flush(ifb_flush), .rpl_flush(rpl_flush),
        .hot_reset_req(hot_reset_req), .cls_valid(cls_valid), .cls_ur(cls_ur),
        .cls_drop(cls_drop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_tlp(input string req, input logic [PW-1:0] src, input logic [4:0] ty,
                            input logic [BW-1:0] bus, input logic exp_ur, input logic exp_drop);
        @(negedge clk);
        tlp_valid = 1'b1; tlp_src_port = src; tlp_type = ty; tlp_bus = bus;
        @(negedge clk);
        tlp_valid = 1'b0;
        chk({req, " valid"}, {31'd0, cls_valid}, 32'd1);
        chk({req, " ur/drop"}, {30'd0, cls_ur, cls_drop}, {30'd0, exp_ur, exp_drop});
    endtask

    task automatic test_reset();
        chk("R4 reset flush", {ifb_flush, rpl_flush}, '0);
        chk("R3 reset hot reset", {31'd0, hot_reset_req}, 32'd0);
        chk("R5 reset verdict", {29'd0, cls_valid, cls_ur, cls_drop}, 32'd0);
    endtask

    task automatic test_all_up();
        send_tlp("R9 all up request", 2'd0, T_MRD, 8'd6, 1'b0, 1'b0);
        send_tlp("R9 all up completion", 2'd1, T_CPL, 8'd12, 1'b0, 1'b0);
    endtask

    task automatic test_downstream_drop();
        @(negedge clk);
        dl_up[2] = 1'b0;
        @(negedge clk);
        chk("R1 ifb pulse", {28'd0, ifb_flush}, 32'b0100);
        chk("R2 rpl pulse", {28'd0, rpl_flush}, 32'b0100);
        chk("R3 no hot reset downstream", {31'd0, hot_reset_req}, 32'd0);
        @(negedge clk);
        chk("R1 ifb single cycle", {28'd0, ifb_flush}, 32'd0);
        chk("R2 rpl single cycle", {28'd0, rpl_flush}, 32'd0);
    endtask

    task automatic test_classify();
        send_tlp("R6 memory read", 2'd0, T_MRD, 8'd7, 1'b1, 1'b0);
        send_tlp("R6 config", 2'd3, T_CFG, 8'd6, 1'b1, 1'b0);
        send_tlp("R6 message", 2'd1, T_MSG, 8'd8, 1'b1, 1'b0);
        send_tlp("R7 completion", 2'd0, T_CPL, 8'd7, 1'b0, 1'b1);
        send_tlp("R7 locked completion", 2'd3, T_CPLLK, 8'd9, 1'b0, 1'b1);
        send_tlp("R8 bus at secondary", 2'd0, T_MRD, 8'd5, 1'b1, 1'b0);
        send_tlp("R8 bus at subordinate", 2'd0, T_CPL, 8'd9, 1'b0, 1'b1);
        send_tlp("R8 bus below secondary", 2'd0, T_MRD, 8'd4, 1'b0, 1'b0);
        send_tlp("R8 bus above subordinate", 2'd0, T_MRD, 8'd10, 1'b0, 1'b0);
        send_tlp("R6 arrival port excluded", 2'd2, T_MRD, 8'd7, 1'b0, 1'b0);
    endtask

    task automatic test_two_down();
        @(negedge clk);
        dl_up[3] = 1'b0;
        @(negedge clk);
        chk("R1 second port pulse", {28'd0, ifb_flush}, 32'b1000);
        send_tlp("R6 port 3 range", 2'd1, T_MRD, 8'd20, 1'b1, 1'b0);
        send_tlp("R6 port 2 still down", 2'd1, T_MRD, 8'd5, 1'b1, 1'b0);
        send_tlp("R9 port 1 up", 2'd0, T_MRD, 8'd3, 1'b0, 1'b0);
    endtask

    task automatic test_link_returns();
        @(negedge clk);
        dl_up[2] = 1'b1;
        dl_up[3] = 1'b1;
        @(negedge clk);
        chk("R4 no flush on return", {ifb_flush, rpl_flush}, '0);
        send_tlp("R4 filtering ended", 2'd0, T_MRD, 8'd7, 1'b0, 1'b0);
        send_tlp("R4 filtering ended cpl", 2'd1, T_CPL, 8'd15, 1'b0, 1'b0);
    endtask

    task automatic test_upstream_drop();
        @(negedge clk);
        dl_up[0] = 1'b0;
        @(negedge clk);
        chk("R1 upstream ifb pulse", {28'd0, ifb_flush}, 32'b0001);
        chk("R2 upstream rpl pulse", {28'd0, rpl_flush}, 32'b0001);
        chk("R3 hot reset raised", {31'd0, hot_reset_req}, 32'd1);
        @(negedge clk);
        chk("R3 hot reset single cycle", {31'd0, hot_reset_req}, 32'd0);
        send_tlp("R9 upstream not filtered", 2'd1, T_MRD, 8'd25, 1'b0, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        dl_up = '1;
        repeat (2) @(negedge clk);
        test_all_up();
        test_downstream_drop();
        test_classify();
        test_two_down();
        test_link_returns();
        test_upstream_drop();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule